// File: doc/BRIEF.md
# Presettable Cascadable Up/Down Counter Stage

This block is one stage of a synchronous binary counter. On each rising clock edge it does one of four things: it takes a parallel word, steps up by one, steps down by one, or keeps its value. The data input is taken whenever the active-low load control is asserted. When the block is not loading, it counts only while both active-low count enables are asserted. One enable only gates the local count. The other gates the local count and also the terminal-count output.

The terminal-count output is active low and fully combinational. It asserts while the chain enable is asserted and the count sits at the end of its range for the selected direction: all ones when counting up, all zeros when counting down. To build a wider counter, place several stages on the same clock, direction, load and local enable. Connect each stage's terminal count to the chain enable of the next more significant stage. A carry then ripples through the chain with no extra clock cycle. The stage width is a parameter, four by default.

Top module: `updn_cnt_stage`

## Requirements
- R1: The count changes only on a rising clock edge. Input changes between edges leave `cnt` unchanged. There is no asynchronous load or clear.
- R2: While `load_n` is 0 at a rising edge, `cnt` takes the value of `din` on that edge, whatever `en_loc_n` and `en_chain_n` are.
- R3: With `load_n`=1, `en_loc_n`=0, `en_chain_n`=0 and `dir_up`=1, `cnt` goes up by one at each edge and wraps from all ones to zero.
- R4: With `load_n`=1, `en_loc_n`=0, `en_chain_n`=0 and `dir_up`=0, `cnt` goes down by one at each edge and wraps from zero to all ones.
- R5: With `load_n`=1 and either `en_loc_n` or `en_chain_n` at 1, `cnt` holds its value across the edge.
- R6: `tc_n` is 0 exactly when `en_chain_n` is 0 and `cnt` is all ones with `dir_up`=1, or all zeros with `dir_up`=0. It follows changes of `dir_up` and `en_chain_n` with no clock edge.
- R7: Stages that share `clk`, `dir_up`, `load_n` and `en_loc_n` form one wider up/down counter when each `tc_n` drives the next stage's `en_chain_n`. The last stage's `tc_n` marks the end of the full range.
- R8: A load takes priority over counting. With `load_n`=0 and both enables at 0, the result is `din` and not a stepped value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| load_n | input | 1 | Parallel load, active low |
| din | input | WIDTH | Parallel data to load |
| dir_up | input | 1 | Count direction: 1 counts up, 0 counts down |
| en_loc_n | input | 1 | Local count enable, active low |
| en_chain_n | input | 1 | Chain count enable, active low; also gates `tc_n` |
| cnt | output | WIDTH | Current count |
| tc_n | output | 1 | Terminal count, active low, combinational |

## Verification
The only state is the count register, so any fault in the next-value logic shows on `cnt` at the first edge after the stimulus that triggers it. A wrong step, a missed hold or a load that loses to counting is seen one cycle later. A fault in the terminal-count decode shows at once on `tc_n`. In a cascade, a wrong `tc_n` also makes the upper stage step or stall at the next edge. Directed vectors cover loads, wraps in both directions and holds. A long random walk on a three-stage chain is checked every cycle against an integer model.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

    // Operation chosen for the coming clock edge
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } op_e;

endpackage

// File: rtl/updn_mode_sel.sv
module updn_mode_sel
    import updn_cnt_pkg::*;
(
    input  logic load_n,
    input  logic dir_up,
    input  logic en_loc_n,
    input  logic en_chain_n,
    output op_e  op
);

    logic count_ok;

    always_comb begin
        count_ok = ~en_loc_n & ~en_chain_n;
        if (!load_n) begin
            op = OP_LOAD;          // load wins over everything
        end else if (count_ok) begin
            op = dir_up ? OP_INC : OP_DEC;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/updn_step.sv
module updn_step
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] count_q,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] count_d
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (op)
            OP_LOAD: count_d = load_val;
            OP_INC:  count_d = count_q + ONE;   // wraps modulo 2**WIDTH
            OP_DEC:  count_d = count_q - ONE;
            default: count_d = count_q;
        endcase
    end

endmodule

// File: rtl/updn_tc_decode.sv
module updn_tc_decode #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count_q,
    input  logic             dir_up,
    input  logic             en_chain_n,
    output logic             tc_n
);

    logic at_top;
    logic at_bottom;

    always_comb begin
        at_top    = &count_q;
        at_bottom = ~|count_q;
        tc_n      = ~(~en_chain_n & (dir_up ? at_top : at_bottom));
    end

endmodule

// File: rtl/updn_cnt_stage.sv
module updn_cnt_stage
    import updn_cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             dir_up,
    input  logic             en_loc_n,
    input  logic             en_chain_n,
    output logic [WIDTH-1:0] cnt,
    output logic             tc_n
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } state_t;

    state_t           st_q;
    state_t           st_d;
    op_e              op;
    logic [WIDTH-1:0] step_cnt;

    updn_mode_sel u_mode (
        .load_n     (load_n),
        .dir_up     (dir_up),
        .en_loc_n   (en_loc_n),
        .en_chain_n (en_chain_n),
        .op         (op)
    );

    updn_step #(.WIDTH(WIDTH)) u_step (
        .op       (op),
        .count_q  (st_q.count),
        .load_val (din),
        .count_d  (step_cnt)
    );

    updn_tc_decode #(.WIDTH(WIDTH)) u_tc (
        .count_q    (st_q.count),
        .dir_up     (dir_up),
        .en_chain_n (en_chain_n),
        .tc_n       (tc_n)
    );

    always_comb begin
        st_d       = st_q;
        st_d.count = step_cnt;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt = st_q.count;

    // R2 / R8: a load copies din regardless of the enables
    a_r2_load_copies: assert property (@(posedge clk)
        !load_n |=> cnt == $past(din));

    // R5: any deasserted enable without load keeps the count
    a_r5_hold: assert property (@(posedge clk)
        (load_n && (en_loc_n || en_chain_n)) |=> $stable(cnt));

    // R3: counting up moves by exactly +1 modulo 2**WIDTH
    a_r3_step_up: assert property (@(posedge clk)
        (load_n && !en_loc_n && !en_chain_n && dir_up)
            |=> (cnt - $past(cnt)) == WIDTH'(1));

    // R4: counting down moves by exactly -1 modulo 2**WIDTH
    a_r4_step_down: assert property (@(posedge clk)
        (load_n && !en_loc_n && !en_chain_n && !dir_up)
            |=> ($past(cnt) - cnt) == WIDTH'(1));

    // R6: terminal count only with chain enable and an end value
    a_r6_tc_gated: assert property (@(posedge clk)
        !tc_n |-> (!en_chain_n && (cnt == ALL_ONES || cnt == '0)));

endmodule

// File: tb/updn_cnt_stage_tb.sv
module updn_cnt_stage_tb;

    localparam int SW     = 4;
    localparam int NST    = 3;
    localparam int TW     = SW * NST;
    localparam int NVEC   = 22;
    localparam int TMAX   = (1 << TW) - 1;

    // vector: [27]load_n [26]dir_up [25]en_loc_n [24]chain_n [23:12]din [11:0]expected
    localparam logic [27:0] VEC [NVEC] = '{
        28'h4_00D_00D, 28'hC_000_00E, 28'hC_000_00F, 28'hC_000_010,
        28'hC_000_011, 28'hC_000_012, 28'hE_000_012, 28'h8_000_011,
        28'h8_000_010, 28'h8_000_00F, 28'h8_000_00E, 28'h8_000_00D,
        28'h4_FFE_FFE, 28'hC_000_FFF, 28'hC_000_000, 28'h8_000_FFF,
        28'h8_000_FFE, 28'h7_0FF_0FF, 28'hD_000_0FF, 28'hC_000_100,
        28'h9_000_100, 28'h8_000_0FF
    };

    logic          clk = 1'b0;
    logic          load_n;
    logic [TW-1:0] din;
    logic          dir_up;
    logic          loc_n;
    logic          chain_n;
    logic [SW-1:0] cnt_s [NST];
    logic [NST-1:0] tc_s;
    logic [NST-1:0] chain_in;
    logic [TW-1:0] cnt_all;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    assign chain_in = {tc_s[NST-2:0], chain_n};
    assign cnt_all  = {cnt_s[2], cnt_s[1], cnt_s[0]};

    for (genvar k = 0; k < NST; k++) begin : g_stage
        updn_cnt_stage #(.WIDTH(SW)) u_dut (
            .clk        (clk),
            .load_n     (load_n),
            .din        (din[k*SW +: SW]),
            .dir_up     (dir_up),
            .en_loc_n   (loc_n),
            .en_chain_n (chain_in[k]),
            .cnt        (cnt_s[k]),
            .tc_n       (tc_s[k])
        );
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int tc0_exp(input int full);
        int nib = full & 15;
        return (!chain_n && (dir_up ? nib == 15 : nib == 0)) ? 0 : 1;
    endfunction

    function automatic int tc2_exp(input int full);
        return (!chain_n && (dir_up ? full == TMAX : full == 0)) ? 0 : 1;
    endfunction

    initial begin
        int            model;
        logic [15:0]   lfsr;
        load_n  = 1'b0;
        din     = '0;
        dir_up  = 1'b1;
        loc_n   = 1'b0;
        chain_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // initial state established through a load of zero (R2)
        check("R2 initial load", int'(cnt_all), 0);

        // vector table walk (R2 R3 R4 R5 R7 R8)
        for (int i = 0; i < NVEC; i++) begin
            load_n  = VEC[i][27];
            dir_up  = VEC[i][26];
            loc_n   = VEC[i][25];
            chain_n = VEC[i][24];
            din     = VEC[i][23:12];
            @(posedge clk);
            @(negedge clk);
            check("R2/R3/R4/R5/R8 vector", int'(cnt_all), int'(VEC[i][11:0]));
            check("R7 chain tc", int'(tc_s[2]), tc2_exp(int'(cnt_all)));
        end

        // R1: input changes between edges do not move the count
        load_n = 1'b0;
        din    = 12'h555;
        #5;
        check("R1 no change before edge", int'(cnt_all), 'h0FF);
        @(posedge clk);
        @(negedge clk);
        check("R1 change on edge", int'(cnt_all), 'h555);

        // R6: terminal count follows dir_up and chain enable without a clock
        din = 12'h00F;
        @(posedge clk);
        @(negedge clk);
        load_n = 1'b1; loc_n = 1'b1; chain_n = 1'b0; dir_up = 1'b1;
        #1 check("R6 tc at top counting up", int'(tc_s[0]), 0);
        dir_up = 1'b0;
        #1 check("R6 tc drops when direction flips", int'(tc_s[0]), 1);
        dir_up = 1'b1; chain_n = 1'b1;
        #1 check("R6 tc gated by chain enable", int'(tc_s[0]), 1);
        load_n = 1'b0; din = 12'h000; chain_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        load_n = 1'b1; dir_up = 1'b0;
        #1 check("R6 tc at zero counting down", int'(tc_s[0]), 0);
        check("R7 full-range tc at zero down", int'(tc_s[2]), 0);

        // R8: load with both enables active gives din, not a step
        load_n = 1'b0; loc_n = 1'b0; chain_n = 1'b0; dir_up = 1'b1; din = 12'h7A3;
        @(posedge clk);
        @(negedge clk);
        check("R8 load beats count", int'(cnt_all), 'h7A3);

        // random walk of the 12-bit chain against an integer model (R7)
        model = 'h7A3;
        lfsr  = 16'hACE1;
        for (int c = 0; c < 2000; c++) begin
            lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            load_n  = (lfsr[3:0] != 4'h0);
            din     = lfsr[15:4];
            loc_n   = lfsr[5] & lfsr[6];
            chain_n = lfsr[7] & lfsr[8];
            dir_up  = lfsr[9] | lfsr[11];
            #1 check("R7 tc0 comb", int'(tc_s[0]), tc0_exp(model));
            check("R7 tc top comb", int'(tc_s[2]), tc2_exp(model));
            if (!load_n)
                model = int'(din);
            else if (!loc_n && !chain_n)
                model = dir_up ? ((model + 1) & TMAX) : ((model - 1) & TMAX);
            @(posedge clk);
            @(negedge clk);
            check("R7 chain vs model", int'(cnt_all), model);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule